// File: doc/BRIEF.md
# Watchdog and interval timer

An 8-bit up-counter advances on ticks from a free-running 17-bit divider of the system clock. A 3-bit rate code picks one of eight divider taps. When the counter steps from 0xFF to 0x00, the result depends on the mode bit.

- In interval mode, the overflow latches a flag and raises an interrupt request.
- In watchdog mode with the external reset-enable input high, the overflow emits a one-cycle reset request instead. The flag is left clear, because the reset it asks for clears it.

Software uses a small register bus with two registers, control/status at address 0 and the counter at address 1. Writes to the control register are accepted only with the key 0xA5 in the upper data byte. Writes to the counter are accepted only with the key 0x5A. To clear the latched flag, software must first read the control register while the flag is set, then write 0 to the flag bit.

Top module: `tick_guard_timer`

## Requirements
- R1: When the counter steps from 0xFF to 0x00 on a tick, the overflow flag (control bit 7) becomes 1. The only exception is watchdog mode with reset-enable high.
- R2: The flag returns to 0 only through this sequence: a control read while it is 1, then a keyed control write with bit 7 = 0. A keyed write with bit 7 = 0 and no such read leaves it set. Writing 1 to bit 7 never sets it.
- R3: With the run bit (control bit 5) at 0, the counter reads 0x00 and stays there. With the run bit at 1, the counter adds one per prescaler tick.
- R4: The interrupt output equals the flag while the mode bit (control bit 6) is 0. It is 0 while the mode bit is 1.
- R5: In watchdog mode (bit 6 = 1) with reset-enable high, each overflow gives exactly one reset-request pulse, one clock wide. Afterwards the flag reads 0.
- R6: In watchdog mode with reset-enable low, an overflow gives no reset request, and the flag becomes 1.
- R7: Rate code bits 2..0, values 0 to 7, divide the clock by 2, 64, 128, 512, 2048, 8192, 32768 and 131072. Consecutive overflows from a counter reloaded with 0xFF are exactly that many clocks apart.
- R8: A running counter overflows once every 256 ticks, which is 512 clocks at code 0.
- R9: After reset the control register reads 0x18 (flag 0, interval mode, halted, code 0), the counter reads 0x00, and both request outputs are 0.
- R10: A control write takes effect only when data bits 15..8 equal 0xA5. Any other key leaves the register unchanged.
- R11: A counter write with data bits 15..8 equal to 0x5A loads bits 7..0 into the counter. A write with any other key is ignored.
- R12: Address 0 reads {flag, mode, run, 1, 1, code[2:0]}. Address 1 reads the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, used to arm the flag clear |
| bus_addr | input | 1 | 0 = control/status, 1 = counter |
| bus_wdata | input | 16 | Key in [15:8], data in [7:0] |
| bus_rdata | output | 8 | Read data for the addressed register |
| rst_en | input | 1 | Allows reset requests in watchdog mode |
| irq | output | 1 | Interval interrupt request |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Random keyed and unkeyed control writes check that only the right key changes the register, and that a halted counter stays at zero. Directed overflows in each mode separate the interrupt path from the reset path. Writes of 0 made with and without a prior read separate an armed clear from an unarmed one. Reloading the counter with 0xFF at each rate code from 1 to 6, and free running at code 0, measures the exact tick spacing and shows the tap chosen for each code.

// File: rtl/tick_guard_pkg.sv
package tick_guard_pkg;

  localparam int DIV_W  = 17;
  localparam int SEL_W  = 3;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic             flag;
    logic             wdog;
    logic             run;
    logic [SEL_W-1:0] sel;
  } ctrl_t;

  // divider bit whose rising edge makes a tick for a rate code
  function automatic logic [4:0] tap_bit(input logic [SEL_W-1:0] sel);
    if (sel == 3'd0) return 5'd0;
    if (sel == 3'd1) return 5'd5;
    return {1'b0, sel, 1'b0} + 5'd2;
  endfunction

  function automatic logic [BYTE_W-1:0] ctrl_byte(input ctrl_t c);
    return {c.flag, c.wdog, c.run, 2'b11, c.sel};
  endfunction

endpackage

// File: rtl/tg_prescaler.sv
module tg_prescaler
  import tick_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] want;
  logic [DIV_W-1:0] mask;
  logic [4:0]       tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // selected bit has just risen: it is 1 and all lower bits are 0
  always_comb begin
    tap    = tap_bit(sel_i);
    want   = DIV_W'(1) << tap;
    mask   = (want << 1) - 1'b1;
    tick_o = (div_q & mask) == want;
  end

  // two ticks never arrive back to back unless the code just changed
  assert_tick_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (!tick_o || !$stable(sel_i)));

endmodule

// File: rtl/tg_counter.sv
module tg_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] count_q;

  assign ovf_o   = run_i && tick_i && !load_i && (count_q == TOP);
  assign count_o = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (!run_i) count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (tick_i) count_q <= count_q + 1'b1;
  end

  assert_halt_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (count_q == '0));

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (count_q == '0));

endmodule

// File: rtl/tg_ctrl.sv
module tg_ctrl
  import tick_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic             wflag_i,
  input  logic             wwdog_i,
  input  logic             wrun_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic             ovf_i,
  input  logic             rst_en_i,
  output ctrl_t            ctrl_o,
  output logic             rst_req_o
);

  ctrl_t ctrl_q;
  logic  armed_q;
  logic  rst_req_q;
  logic  set_ev;
  logic  clr_ev;
  logic  auto_ev;

  assign auto_ev = ovf_i && ctrl_q.wdog && rst_en_i;
  assign set_ev  = ovf_i && !auto_ev;
  assign clr_ev  = fire_i && armed_q && !wflag_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      armed_q   <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= auto_ev;
      if (fire_i) begin
        ctrl_q.wdog <= wwdog_i;
        ctrl_q.run  <= wrun_i;
        ctrl_q.sel  <= wsel_i;
        armed_q     <= 1'b0;
      end else if (rd_i && !addr_i && ctrl_q.flag) begin
        armed_q <= 1'b1;
      end
      if (set_ev)                 ctrl_q.flag <= 1'b1;
      else if (clr_ev || auto_ev) ctrl_q.flag <= 1'b0;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign rst_req_o = rst_req_q;

  assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i && !(ctrl_q.wdog && rst_en_i)) |=> ctrl_q.flag);

  assert_flag_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q.flag) |-> ($past(wr_i && !addr_i) || rst_req_q));

  assert_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_en_i |=> !rst_req_q);

endmodule

// File: rtl/tick_guard_timer.sv
module tick_guard_timer
  import tick_guard_pkg::*;
#(
  parameter int          CNT_W    = 8,
  parameter logic [7:0]  KEY_CTRL = 8'hA5,
  parameter logic [7:0]  KEY_CNT  = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        rst_en,
  output logic        irq,
  output logic        rst_req
);

  ctrl_t            ctrl;
  logic             tick;
  logic             ovf;
  logic             ctrl_fire;
  logic             cnt_load;
  logic [CNT_W-1:0] count;
  logic             unused_bits;

  assign ctrl_fire   = bus_wr && !bus_addr && (bus_wdata[15:8] == KEY_CTRL);
  assign cnt_load    = bus_wr &&  bus_addr && (bus_wdata[15:8] == KEY_CNT);
  assign unused_bits = ^bus_wdata[4:3];

  tg_prescaler u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (ctrl.sel),
    .tick_o (tick)
  );

  tg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (ctrl.run),
    .tick_i     (tick),
    .load_i     (cnt_load),
    .load_val_i (bus_wdata[CNT_W-1:0]),
    .count_o    (count),
    .ovf_o      (ovf)
  );

  tg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (ctrl_fire),
    .rd_i      (bus_rd),
    .wr_i      (bus_wr),
    .addr_i    (bus_addr),
    .wflag_i   (bus_wdata[7]),
    .wwdog_i   (bus_wdata[6]),
    .wrun_i    (bus_wdata[5]),
    .wsel_i    (bus_wdata[2:0]),
    .ovf_i     (ovf),
    .rst_en_i  (rst_en),
    .ctrl_o    (ctrl),
    .rst_req_o (rst_req)
  );

  assign irq       = ctrl.flag && !ctrl.wdog;
  assign bus_rdata = bus_addr ? BYTE_W'(count) : ctrl_byte(ctrl);

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_irq_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.wdog && !$past(ctrl.wdog)) |-> !irq);

endmodule

// File: tb/tick_guard_timer_bench.sv
module tick_guard_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 195000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        rst_en = 1'b0;
  logic        irq;
  logic        rst_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int pulses = 0;
  int last_pulse = 0;
  int doubles = 0;
  bit prev_req = 1'b0;
  bit done = 1'b0;

  tick_guard_timer u_tick_guard_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_en(rst_en), .irq(irq), .rst_req(rst_req)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int div_of(input int code);
    case (code)
      0: return 2;       1: return 64;     2: return 128;    3: return 512;
      4: return 2048;    5: return 8192;   6: return 32768;  default: return 131072;
    endcase
  endfunction

  function automatic logic [7:0] ctrl_exp(input bit f, input bit m, input bit r, input int code);
    return {f, m, r, 2'b11, 3'(code)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_req) begin
      pulses++;
      last_pulse = cyc;
      if (prev_req) doubles++;
    end
    prev_req = rst_req;
    if (cyc > LIMIT) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, LIMIT);
      finish_run();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input bit a, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_pulse(output int t);
    int start = pulses;
    for (int i = 0; i < 140000 && pulses == start; i++) @(negedge clk);
    t = last_pulse;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 700 && !irq; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    bit m, r;
    int code, t1, t2, p0;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 / R12 reset state
    rd(0, v); check("R9 ctrl", v, 8'h18);
    rd(1, v); check("R9 count", v, 0);
    check("R9 irq", irq, 0);
    check("R9 rst_req", rst_req, 0);

    // R10 wrong key
    wr(0, {8'h3C, 8'h67});
    rd(0, v); check("R10 badkey", v, 8'h18);

    // R10 / R3 / R12 random keyed and unkeyed writes
    m = 0; r = 0; code = 0;
    for (int i = 0; i < 24; i++) begin
      logic [7:0] key, dat;
      dat = 8'($urandom);
      key = ($urandom % 2) ? 8'hA5 : 8'($urandom);
      wr(0, {key, dat});
      if (key == 8'hA5) begin m = dat[6]; r = dat[5]; code = int'(dat[2:0]); end
      rd(0, v); check("R10 rand", v & 8'h7F, ctrl_exp(0, m, r, code) & 8'h7F);
      if (!r) begin rd(1, v); check("R3 halted", v, 0); end
    end

    // R1 / R4 interval overflow
    wr(0, {8'hA5, 8'h00});
    wr(0, {8'hA5, 8'h20});
    wait_irq();
    check("R4 irq on ovf", irq, 1);
    rd(1, v); check("R1 wrapped low", (v < 8'h08) ? 1 : 0, 1);

    // R2 write 0 without read: flag kept
    wr(0, {8'hA5, 8'h20});
    check("R2 no-arm clear", irq, 1);
    rd(0, v); check("R1 flag set", v, ctrl_exp(1, 0, 1, 0));
    wr(0, {8'hA5, 8'h20});
    check("R2 armed clear", irq, 0);
    rd(0, v); check("R2 flag clear", v[7], 0);
    wr(0, {8'hA5, 8'hA0});
    rd(0, v); check("R2 write 1", v[7], 0);

    // R4 mode switch hides flag
    wait_irq();
    wr(0, {8'hA5, 8'hE0});
    check("R4 irq off in watchdog", irq, 0);
    rd(0, v); check("R4 flag kept", v[7], 1);
    wr(0, {8'hA5, 8'h60});
    rd(0, v); check("R2 clear watchdog", v[7], 0);

    // R6 watchdog with reset disabled
    p0 = pulses;
    repeat (600) @(negedge clk);
    check("R6 no pulse", pulses - p0, 0);
    rd(0, v); check("R6 flag set", v[7], 1);
    check("R6 irq", irq, 0);

    // R5 reset request clears flag
    rst_en = 1'b1;
    p0 = pulses;
    wait_pulse(t1);
    repeat (3) @(negedge clk);
    check("R5 one pulse", pulses - p0, 1);
    rd(0, v); check("R5 flag cleared", v[7], 0);

    // R8 period at code 0
    wait_pulse(t1);
    wait_pulse(t2);
    check("R8 period", t2 - t1, 512);

    // R7 rate codes 1..6
    for (int c = 1; c < 7; c++) begin
      wr(0, {8'hA5, 8'h40});
      wr(0, {8'hA5, 8'h60 | 8'(c)});
      wr(1, {8'h5A, 8'hFF});
      wait_pulse(t1);
      wr(1, {8'h5A, 8'hFF});
      wait_pulse(t2);
      check($sformatf("R7 code %0d", c), t2 - t1, div_of(c));
    end
    rst_en = 1'b0;

    // R11 keyed counter load
    wr(0, {8'hA5, 8'h27});
    wr(1, {8'h5A, 8'h40});
    rd(1, v); check("R11 load", (v == 8'h40 || v == 8'h41) ? 1 : 0, 1);
    wr(1, {8'hA5, 8'h90});
    rd(1, v); check("R11 badkey", (v == 8'h40 || v == 8'h41) ? 1 : 0, 1);

    // R3 disable forces zero and halts
    wr(0, {8'hA5, 8'h00});
    rd(1, v); check("R3 zero", v, 0);
    repeat (300) @(negedge clk);
    rd(1, v); check("R3 held", v, 0);

    check("R5 width", doubles, 0);
    finish_run();
  end

endmodule